// File: doc/BRIEF.md
# Interval Down-Counter Timer

This block is a 32-bit interval timer that sits on a plain word-wide register bus and drives a single active-high interrupt. Software sees four word registers: a free scratch word, a control word, a reload period, and the live count. Once the run bit is set, the live count steps down by one on every pulse of an external tick strobe. When it reaches zero it either reloads from the period register or holds at zero, depending on one control bit.

That same control bit also gates the interrupt. The interrupt is a registered level that is high whenever the count is zero and the bit is set, whether or not the timer is running. The live count can be read but never written. Setting the run bit starts counting from whatever value the live count already holds. Only whole-word accesses to the four defined offsets are legal, and the bus carries each word with its most significant byte in the lowest byte lane. Any other access is acknowledged with an error and changes nothing.

Top module: `interval_timer`

## Requirements
- R1: After reset, the scratch, control, period and live-count registers read as zero, and `irq`, `bus_ack` and `bus_err` are low.
- R2: A request that `bus_req` samples high at a clock edge is acknowledged by `bus_ack` high for exactly the following cycle. Offset 0x0 is the scratch word, 0x4 is control, 0x8 is period and 0xC is the live count. A read returns its data on `bus_rdata` in the acknowledge cycle, and a legal write is visible to a read issued after the write is acknowledged.
- R3: Bus data lanes are big-endian. Bits [7:0] of `bus_wdata`/`bus_rdata` carry register bits [31:24], and bits [31:24] of the bus carry register bits [7:0].
- R4: The live count changes only on a cycle where `tick` is high and control bit 2 (run) is 1. In any other cycle it holds its value.
- R5: On a running tick with a nonzero count, the count decreases by exactly one.
- R6: On a running tick with a count of zero, the count loads the period value if control bit 0 (reload) is 1; otherwise it stays zero.
- R7: `irq` is high in a cycle exactly when the live count is zero and control bit 0 is 1 in that cycle. It follows a tick or control write one cycle later, and it does not depend on the run bit.
- R8: An access is illegal when `bus_size` is not 2'b10 (word), when the offset is not 0x0, 0x4, 0x8 or 0xC, or when it is a write to 0xC. An illegal access gets `bus_err` high together with `bus_ack`, and it leaves every register unchanged.
- R9: The scratch word at 0x0 is plain storage. Counting, reloads and interrupts never change it.
- R10: Writing control with the run bit set does not load the live count from period. Counting resumes from the count already held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle count enable strobe |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_size | input | 2 | Access size, 2'b10 = word; other values illegal |
| bus_wdata | input | 32 | Write data, big-endian lanes |
| bus_ack | output | 1 | Access acknowledge, one cycle after the request |
| bus_err | output | 1 | Illegal access flag, valid with bus_ack |
| bus_rdata | output | 32 | Read data, big-endian lanes, valid with bus_ack |
| irq | output | 1 | Interrupt level |

## Verification
The bound checker checks the counting rules on every cycle. It confirms that the count holds unless a running tick arrives, that a nonzero count steps down by one, and that a zero count reloads or holds as the reload bit dictates. It also checks that the interrupt level always matches a zero count with the reload bit set, and that the acknowledge and error flags follow each request. The lane ordering, the register offsets, the absence of any effect from illegal accesses, and the fact that starting the timer does not reload the count are only shown by the bench scenarios. Those scenarios write known words and read them back through the bus.

// File: rtl/interval_timer_pkg.sv
// Package: shared constants, access size codes and lane helpers for the
// interval timer. Assumes a 32-bit register word built from 8-bit lanes.
package interval_timer_pkg;

    localparam int WORD_W    = 32;
    localparam int LANE_W    = 8;
    localparam int NUM_LANES = WORD_W / LANE_W;

    // Control word bit positions
    localparam int CTL_RELOAD_BIT = 0;
    localparam int CTL_RUN_BIT    = 2;

    // Register byte offsets
    localparam logic [3:0] OFF_SCRATCH = 4'h0;
    localparam logic [3:0] OFF_CONTROL = 4'h4;
    localparam logic [3:0] OFF_PERIOD  = 4'h8;
    localparam logic [3:0] OFF_COUNT   = 4'hC;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_RSVD = 2'b11
    } access_size_e;

    typedef enum logic [1:0] {
        SEL_SCRATCH,
        SEL_CONTROL,
        SEL_PERIOD,
        SEL_COUNT
    } reg_sel_e;

    // Reverse lane order: bus lane 0 holds the register's top byte
    function automatic logic [WORD_W-1:0] lane_swap(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < NUM_LANES; i++) begin
            r[i*LANE_W +: LANE_W] = v[(NUM_LANES-1-i)*LANE_W +: LANE_W];
        end
        return r;
    endfunction

endpackage

// File: rtl/interval_timer_bus.sv
// Module: bus decoder for the interval timer.
// Decodes one single-cycle request per access, qualifies it as legal or
// illegal, issues write strobes for the writable registers and returns
// registered acknowledge, error and read data one cycle later.
// Assumes requests arrive as one-cycle pulses on bus_req.
module interval_timer_bus
    import interval_timer_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [WORD_W-1:0] scratch_q,
    input  logic [WORD_W-1:0] control_q,
    input  logic [WORD_W-1:0] period_q,
    input  logic [WORD_W-1:0] count_q,
    output logic              scratch_we,
    output logic              control_we,
    output logic              period_we,
    output logic [WORD_W-1:0] wr_value,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [WORD_W-1:0] bus_rdata
);

    localparam int HI_W = (ADDR_W > 4) ? ADDR_W - 4 : 1;

    logic     hit;
    logic     legal;
    reg_sel_e sel;
    logic     upper_zero;

    // Purpose: check that address bits above the 16-byte window are clear
    generate
        if (ADDR_W > 4) begin : g_hi
            logic [HI_W-1:0] hi_bits;
            assign hi_bits    = bus_addr[ADDR_W-1:4];
            assign upper_zero = (hi_bits == '0);
        end else begin : g_nohi
            assign upper_zero = 1'b1;
        end
    endgenerate

    // Purpose: map the offset onto a register selector
    always_comb begin
        hit = upper_zero;
        sel = SEL_SCRATCH;
        case (bus_addr[3:0])
            OFF_SCRATCH: sel = SEL_SCRATCH;
            OFF_CONTROL: sel = SEL_CONTROL;
            OFF_PERIOD:  sel = SEL_PERIOD;
            OFF_COUNT:   sel = SEL_COUNT;
            default:     hit = 1'b0;
        endcase
    end

    // Purpose: qualify the access (word size, mapped offset, not a count write)
    always_comb begin
        legal = hit && (bus_size == SZ_WORD) && !(bus_we && sel == SEL_COUNT);
    end

    // Purpose: generate per-register write strobes and the lane-swapped value
    always_comb begin
        wr_value   = lane_swap(bus_wdata);
        scratch_we = bus_req && bus_we && legal && (sel == SEL_SCRATCH);
        control_we = bus_req && bus_we && legal && (sel == SEL_CONTROL);
        period_we  = bus_req && bus_we && legal && (sel == SEL_PERIOD);
    end

    // Purpose: register acknowledge, error flag and read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_err   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_req;
            bus_err   <= bus_req && !legal;
            bus_rdata <= '0;
            if (bus_req && !bus_we && legal) begin
                case (sel)
                    SEL_SCRATCH: bus_rdata <= lane_swap(scratch_q);
                    SEL_CONTROL: bus_rdata <= lane_swap(control_q);
                    SEL_PERIOD:  bus_rdata <= lane_swap(period_q);
                    default:     bus_rdata <= lane_swap(count_q);
                endcase
            end
        end
    end

endmodule

// File: rtl/interval_timer_regs.sv
// Module: software-visible storage of the interval timer.
// Holds the scratch, control and period words. Each word is loaded only by
// its write strobe; no counting logic touches them.
module interval_timer_regs
    import interval_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scratch_we,
    input  logic              control_we,
    input  logic              period_we,
    input  logic [WORD_W-1:0] wr_value,
    output logic [WORD_W-1:0] scratch_q,
    output logic [WORD_W-1:0] control_q,
    output logic [WORD_W-1:0] period_q
);

    // Purpose: scratch word, plain read/write storage
    always_ff @(posedge clk) begin
        if (!rst_n)          scratch_q <= '0;
        else if (scratch_we) scratch_q <= wr_value;
    end

    // Purpose: control word holding the run and reload bits
    always_ff @(posedge clk) begin
        if (!rst_n)          control_q <= '0;
        else if (control_we) control_q <= wr_value;
    end

    // Purpose: reload period
    always_ff @(posedge clk) begin
        if (!rst_n)         period_q <= '0;
        else if (period_we) period_q <= wr_value;
    end

endmodule

// File: rtl/interval_timer_count.sv
// Module: down-counter and interrupt level of the interval timer.
// On a tick while running, a nonzero count drops by one; a zero count reloads
// from the period if reload is set, otherwise it holds at zero. The interrupt
// register tracks the next count and reload bit, so it reflects the state
// of the current cycle. Assumes tick is a one-cycle strobe on clk.
module interval_timer_count
    import interval_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              run,
    input  logic              reload_en,
    input  logic              reload_en_nxt,
    input  logic [WORD_W-1:0] period_q,
    output logic [WORD_W-1:0] count_q,
    output logic              irq
);

    logic [WORD_W-1:0] count_nxt;

    // Purpose: next count from tick, run, reload and the current count
    always_comb begin
        count_nxt = count_q;
        if (tick && run) begin
            if (count_q != '0)  count_nxt = count_q - 1'b1;
            else if (reload_en) count_nxt = period_q;
        end
    end

    // Purpose: live count register
    always_ff @(posedge clk) begin
        if (!rst_n) count_q <= '0;
        else        count_q <= count_nxt;
    end

    // Purpose: registered interrupt level, zero count with reload enabled
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= (count_nxt == '0) && reload_en_nxt;
    end

endmodule

// File: rtl/interval_timer.sv
// Module: interval timer top. Connects the bus decoder, the register store
// and the down-counter. One request per access, one tick strobe input and a
// level interrupt output. Synchronous active-low reset.
module interval_timer
    import interval_timer_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [1:0]        bus_size,
    input  logic [31:0]       bus_wdata,
    output logic              bus_ack,
    output logic              bus_err,
    output logic [31:0]       bus_rdata,
    output logic              irq
);

    logic [WORD_W-1:0] scratch_q;
    logic [WORD_W-1:0] control_q;
    logic [WORD_W-1:0] period_q;
    logic [WORD_W-1:0] count_q;
    logic [WORD_W-1:0] wr_value;
    logic              scratch_we;
    logic              control_we;
    logic              period_we;
    logic              reload_nxt;

    // Purpose: reload bit as it will stand after this edge
    always_comb begin
        reload_nxt = control_we ? wr_value[CTL_RELOAD_BIT] : control_q[CTL_RELOAD_BIT];
    end

    interval_timer_bus #(.ADDR_W(ADDR_W)) bus_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_size   (bus_size),
        .bus_wdata  (bus_wdata),
        .scratch_q  (scratch_q),
        .control_q  (control_q),
        .period_q   (period_q),
        .count_q    (count_q),
        .scratch_we (scratch_we),
        .control_we (control_we),
        .period_we  (period_we),
        .wr_value   (wr_value),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err),
        .bus_rdata  (bus_rdata)
    );

    interval_timer_regs regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .scratch_we (scratch_we),
        .control_we (control_we),
        .period_we  (period_we),
        .wr_value   (wr_value),
        .scratch_q  (scratch_q),
        .control_q  (control_q),
        .period_q   (period_q)
    );

    interval_timer_count count_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .run           (control_q[CTL_RUN_BIT]),
        .reload_en     (control_q[CTL_RELOAD_BIT]),
        .reload_en_nxt (reload_nxt),
        .period_q      (period_q),
        .count_q       (count_q),
        .irq           (irq)
    );

endmodule

// File: rtl/interval_timer_chk.sv
// Module: checker bound to the interval timer top. Watches the bus flags,
// the live count and the interrupt level every cycle.
module interval_timer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic        bus_req,
    input logic        bus_ack,
    input logic        bus_err,
    input logic        irq,
    input logic [31:0] control_q,
    input logic [31:0] period_q,
    input logic [31:0] count_q
);

    logic running_tick;
    assign running_tick = tick && control_q[2];

    assert_ack_follows_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);

    assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);

    assert_err_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    assert_hold_without_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running_tick |=> $stable(count_q));

    assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running_tick && count_q != 32'd0) |=> (count_q == $past(count_q) - 32'd1));

    assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_tick && count_q == 32'd0 && control_q[0]) |=> (count_q == $past(period_q)));

    assert_hold_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (running_tick && count_q == 32'd0 && !control_q[0]) |=> (count_q == 32'd0));

    assert_irq_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq == ((count_q == 32'd0) && control_q[0])));

endmodule

bind interval_timer interval_timer_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_err   (bus_err),
    .irq       (irq),
    .control_q (control_q),
    .period_q  (period_q),
    .count_q   (count_q)
);

// File: tb/interval_timer_tb_top.sv
// Directed bench for the interval timer: one task per scenario.
module interval_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        bus_req = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [1:0]  bus_size = 2'b10;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack;
    logic        bus_err;
    logic [31:0] bus_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    interval_timer dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] swap(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Raw bus access; returns raw read data, ack and err sampled in the ack cycle
    task automatic access(input logic we, input logic [3:0] a, input logic [1:0] sz,
                          input logic [31:0] raw_w, output logic [31:0] raw_r,
                          output logic ack, output logic err);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_size = sz; bus_wdata = raw_w;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
        raw_r = bus_rdata; ack = bus_ack; err = bus_err;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] v);
        logic [31:0] r; logic ack, err;
        access(1'b1, a, 2'b10, swap(v), r, ack, err);
        check("R2 write ack", {31'd0, ack}, 32'd1);
        check("R8 legal write no err", {31'd0, err}, 32'd0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        logic ack, err; logic [31:0] r;
        access(1'b0, a, 2'b10, 32'd0, r, ack, err);
        check("R2 read ack", {31'd0, ack}, 32'd1);
        v = swap(r);
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        check("R1 irq at reset", {31'd0, irq}, 32'd0);
        check("R1 ack at reset", {31'd0, bus_ack}, 32'd0);
        check("R1 err at reset", {31'd0, bus_err}, 32'd0);
        rd(4'h0, v); check("R1 scratch reset", v, 32'd0);
        rd(4'h4, v); check("R1 control reset", v, 32'd0);
        rd(4'h8, v); check("R1 period reset", v, 32'd0);
        rd(4'hC, v); check("R1 count reset", v, 32'd0);
    endtask

    task automatic t_regs_and_lanes();
        logic [31:0] r, v; logic ack, err;
        wr(4'h0, 32'hA5A5_0F0F);
        wr(4'h8, 32'd3);
        rd(4'h0, v); check("R2 scratch readback", v, 32'hA5A5_0F0F);
        rd(4'h8, v); check("R2 period readback", v, 32'd3);
        // R3: raw lanes, bus bits [7:0] carry register bits [31:24]
        access(1'b1, 4'h0, 2'b10, 32'h1122_3344, r, ack, err);
        access(1'b0, 4'h0, 2'b10, 32'd0, r, ack, err);
        check("R3 raw lane round trip", r, 32'h1122_3344);
        rd(4'h0, v); check("R3 register view of lanes", v, 32'h4433_2211);
        wr(4'h0, 32'hA5A5_0F0F);
    endtask

    task automatic t_illegal();
        logic [31:0] r, v; logic ack, err;
        access(1'b1, 4'hC, 2'b10, swap(32'd77), r, ack, err);
        check("R8 count write err", {31'd0, err}, 32'd1);
        check("R8 count write ack", {31'd0, ack}, 32'd1);
        rd(4'hC, v); check("R8 count unchanged", v, 32'd0);
        access(1'b1, 4'h8, 2'b00, swap(32'd9), r, ack, err);
        check("R8 byte size err", {31'd0, err}, 32'd1);
        rd(4'h8, v); check("R8 period unchanged", v, 32'd3);
        access(1'b1, 4'h6, 2'b10, swap(32'd5), r, ack, err);
        check("R8 unmapped offset err", {31'd0, err}, 32'd1);
        rd(4'h4, v); check("R8 control unchanged", v, 32'd0);
        access(1'b0, 4'h1, 2'b10, 32'd0, r, ack, err);
        check("R8 unmapped read err", {31'd0, err}, 32'd1);
        access(1'b0, 4'h0, 2'b01, 32'd0, r, ack, err);
        check("R8 half read err", {31'd0, err}, 32'd1);
    endtask

    task automatic t_count();
        logic [31:0] v;
        // run without reload: zero count holds, no irq
        wr(4'h4, 32'h4);
        pulse_tick();
        rd(4'hC, v); check("R6 zero holds without reload", v, 32'd0);
        check("R7 irq low without reload", {31'd0, irq}, 32'd0);
        // enable reload: irq rises before any tick
        wr(4'h4, 32'h5);
        check("R7 irq with zero count", {31'd0, irq}, 32'd1);
        pulse_tick();
        check("R7 irq drops after reload", {31'd0, irq}, 32'd0);
        rd(4'hC, v); check("R6 reload from period", v, 32'd3);
        repeat (3) @(negedge clk);
        rd(4'hC, v); check("R4 no tick holds count", v, 32'd3);
        pulse_tick();
        rd(4'hC, v); check("R5 decrement", v, 32'd2);
        pulse_tick();
        pulse_tick();
        rd(4'hC, v); check("R5 reaches zero", v, 32'd0);
        check("R7 irq at zero", {31'd0, irq}, 32'd1);
        // stopped: ticks have no effect
        wr(4'h4, 32'h1);
        pulse_tick();
        rd(4'hC, v); check("R4 stopped holds zero", v, 32'd0);
        check("R7 irq independent of run", {31'd0, irq}, 32'd1);
        wr(4'h4, 32'h5);
        pulse_tick();
        rd(4'hC, v); check("R6 reload again", v, 32'd3);
        pulse_tick();
        rd(4'hC, v); check("R5 step to two", v, 32'd2);
        // stop, change period, restart: count is not reloaded by the write
        wr(4'h4, 32'h1);
        wr(4'h8, 32'd9);
        pulse_tick();
        rd(4'hC, v); check("R4 stopped holds two", v, 32'd2);
        wr(4'h4, 32'h5);
        rd(4'hC, v); check("R10 start keeps count", v, 32'd2);
        pulse_tick();
        rd(4'hC, v); check("R10 counts on from held value", v, 32'd1);
        rd(4'h0, v); check("R9 scratch untouched by counting", v, 32'hA5A5_0F0F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs_and_lanes();
        t_illegal();
        t_count();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule